// File: doc/BRIEF.md
# Nibble-wide accumulator processor core

This core is a small processor with a four-bit datapath that completes one instruction on every rising clock edge. It holds two general registers, an output latch, a program counter and a one-bit carry flag. On each cycle it presents the program counter on a read-address port and receives an eight-bit instruction word from an external program store on the same cycle. The upper four bits of the word form the command; the lower four bits form an immediate value.

Every instruction has the same shape: one of four sources is picked, the immediate is added to it, and the four-bit sum is written to exactly one destination. The candidate sources are register A, register B, the input port and constant zero. The candidate destinations are register A, register B, the output latch and the program counter. The select and load signals come directly from individual command bits through a handful of gates. Because of this, some command codes behave as duplicates of others, and the only conditional control flow is a jump taken while the carry flag is clear. The program store and the clock source sit outside the block.

Top module: `nib_core`

## Requirements
- R1: `pgm_addr` always equals the program counter. The word on `pgm_word` is split into a command `c = pgm_word[7:4]` and an immediate `imm = pgm_word[3:0]`.
- R2: The source is chosen by the two-bit code `{c[1], c[0] | c[3]}`. Code 00 selects register A, 01 selects register B, 10 selects `in_port`, and 11 selects zero.
- R3: The value written is `(source + imm) mod 16`, with no carry into the addition.
- R4: When `c[3:2]` is 00, the sum is written to register A. When it is 01, the sum goes to register B. When it is 10, the sum goes to the output latch that drives `out_port`.
- R5: When `c[3:2]` is 11, the program counter is loaded with the sum if `c[0]` is 1 (unconditional) or if the carry flag is 0 (taken while no carry). The encodings are 1111 for jump-to-immediate and 1110 for jump-if-no-carry to the immediate.
- R6: Whenever the program counter is not loaded, it increments by one, wrapping from 15 to 0.
- R7: The carry flag is rewritten on every clock edge with the carry-out of the current addition, whatever the destination.
- R8: Codes 1000 and 1001 both output B+imm. Codes 1010 and 1011 both output imm. Code 1100 is jump-if-no-carry to B+imm, and code 1101 is jump to B+imm.
- R9: A synchronous active-high `rst` clears A, B, the output latch, the program counter and the carry flag to zero.
- R10: At most one destination is written per instruction. The output latch holds its value unless `c[3:2]` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 4 | External input value, usable as a source |
| out_port | output | 4 | Output latch contents |
| pgm_addr | output | 4 | Program store read address (program counter) |
| pgm_word | input | 8 | Instruction word read at `pgm_addr` |

## Verification
The bench builds the core with its default four-bit data width. With that width, the whole sixteen-word program space and every one of the sixteen command codes can be exercised, including the aliased codes and both outcomes of the carry-conditioned jump. Directed programs force carry-out in both states, wrap the program counter past 15, and steer data through B into the output latch. Many random programs with changing input-port values then reach mixed sequences of jumps and register writes. These are compared each cycle against a behavioural model.

// File: rtl/nib_core_pkg.sv
package nib_core_pkg;

    localparam int NIB_W  = 4;
    localparam int CMD_W  = 4;
    localparam int WORD_W = CMD_W + NIB_W;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic [1:0] {
        SRC_REG_A = 2'b00,
        SRC_REG_B = 2'b01,
        SRC_PORT  = 2'b10,
        SRC_ZERO  = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e src;
        logic     ld_a;
        logic     ld_b;
        logic     ld_out;
        logic     ld_pc;
    } ctrl_t;

    // Gate-level decode of the command bits; carry_q is the stored flag.
    function automatic ctrl_t decode_cmd(cmd_t c, logic carry_q);
        ctrl_t r;
        r.src    = src_sel_e'({c[1], c[0] | c[3]});
        r.ld_a   = ~c[3] & ~c[2];
        r.ld_b   = ~c[3] &  c[2];
        r.ld_out =  c[3] & ~c[2];
        r.ld_pc  =  c[3] &  c[2] & (c[0] | ~carry_q);
        return r;
    endfunction

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_core_pkg::*;
(
    input  cmd_t  cmd,
    input  logic  carry_q,
    output ctrl_t ctrl
);
    always_comb ctrl = decode_cmd(cmd, carry_q);
endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import nib_core_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  src_sel_e     src,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    input  logic [W-1:0] port_in,
    input  logic [W-1:0] imm,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] operand;
    logic [W:0]   wide;

    always_comb begin
        unique case (src)
            SRC_REG_A: operand = reg_a;
            SRC_REG_B: operand = reg_b;
            SRC_PORT:  operand = port_in;
            default:   operand = '0;
        endcase
    end

    // Carry-in is fixed at zero.
    assign wide = {1'b0, operand} + {1'b0, imm};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/nib_state.sv
module nib_state
    import nib_core_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] sum,
    input  logic         cout,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pc_q,
    output logic         cf_q
);
    localparam logic [W-1:0] PC_STEP = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            out_q <= '0;
            pc_q  <= '0;
            cf_q  <= 1'b0;
        end else begin
            cf_q <= cout;
            if (ctrl.ld_a)   a_q   <= sum;
            if (ctrl.ld_b)   b_q   <= sum;
            if (ctrl.ld_out) out_q <= sum;
            if (ctrl.ld_pc)  pc_q  <= sum;
            else             pc_q  <= pc_q + PC_STEP;
        end
    end
endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  in_port,
    output logic [NIB_W-1:0]  out_port,
    output logic [NIB_W-1:0]  pgm_addr,
    input  logic [WORD_W-1:0] pgm_word
);
    ctrl_t      ctrl;
    nib_t       a_q, b_q, out_q, pc_q, sum;
    logic       cf_q, cout;

    nib_decode u_dec (
        .cmd     (pgm_word[WORD_W-1:NIB_W]),
        .carry_q (cf_q),
        .ctrl    (ctrl)
    );

    nib_datapath #(.W(NIB_W)) u_dp (
        .src     (ctrl.src),
        .reg_a   (a_q),
        .reg_b   (b_q),
        .port_in (in_port),
        .imm     (pgm_word[NIB_W-1:0]),
        .sum     (sum),
        .cout    (cout)
    );

    nib_state #(.W(NIB_W)) u_st (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .sum   (sum),
        .cout  (cout),
        .a_q   (a_q),
        .b_q   (b_q),
        .out_q (out_q),
        .pc_q  (pc_q),
        .cf_q  (cf_q)
    );

    assign out_port = out_q;
    assign pgm_addr = pc_q;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] pgm_addr,
    input logic [7:0] pgm_word,
    input logic [3:0] out_port,
    input logic [3:0] a_q,
    input logic       cf_q
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R9
    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            reset_state_chk: assert (pgm_addr == 4'd0 && out_port == 4'd0 && cf_q == 1'b0);
        end
    end

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(pgm_word[7] & pgm_word[6]) |=> pgm_addr == 4'($past(pgm_addr) + 4'd1));

    // R5
    jmp_imm_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_word[7:4] == 4'b1111 |=> pgm_addr == $past(pgm_word[3:0]));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(pgm_word[7] & ~pgm_word[6]) |=> $stable(out_port));

    // R4
    mov_a_imm_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_word[7:4] == 4'b0011 |=> a_q == $past(pgm_word[3:0]));

    // R7
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_word[7:4] == 4'b0000 |=> cf_q == ((5'($past(a_q)) + 5'($past(pgm_word[3:0]))) > 5'd15));

    // R8
    out_alias_chk: assert property (@(posedge clk) disable iff (rst)
        pgm_word[7:4] == 4'b1010 |=> out_port == $past(pgm_word[3:0]));
endmodule

bind nib_core nib_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pgm_addr (pgm_addr),
    .pgm_word (pgm_word),
    .out_port (out_port),
    .a_q      (a_q),
    .cf_q     (cf_q)
);

// File: tb/nib_core_tb_top.sv
module nib_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] in_port = 4'd0;
    logic [3:0] out_port, pgm_addr;
    logic [7:0] pgm_word;
    logic [7:0] prog [16];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_a, m_b, m_out, m_pc, m_cf;

    always #2 clk = ~clk;

    always_comb pgm_word = prog[pgm_addr];

    nib_core dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_port  (in_port),
        .out_port (out_port),
        .pgm_addr (pgm_addr),
        .pgm_word (pgm_word)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: one instruction on the word at m_pc.
    task automatic model_step(int pin);
        int op, imm, src, s;
        op  = prog[m_pc] >> 4;
        imm = prog[m_pc] & 15;
        if (op == 0 || op == 4)                      src = m_a;
        else if (op == 2 || op == 6)                 src = pin;
        else if (op == 1 || op == 5 || op == 8 || op == 9 || op == 12 || op == 13) src = m_b;
        else                                         src = 0;
        s = src + imm;
        m_cf = (s > 15) ? 1 : 0;
        s = s & 15;
        if (op < 4)       begin m_a = s;   m_pc = (m_pc + 1) % 16; end
        else if (op < 8)  begin m_b = s;   m_pc = (m_pc + 1) % 16; end
        else if (op < 12) begin m_out = s; m_pc = (m_pc + 1) % 16; end
        else if (op == 13 || op == 15 || prev_cf_clear) m_pc = s;
        else m_pc = (m_pc + 1) % 16;
    endtask

    bit prev_cf_clear;

    task automatic run_prog(string tag, int cycles, bit rand_in);
        int pin;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "reset out_port", out_port, 0);
        chk("R9", "reset pgm_addr", pgm_addr, 0);
        m_a = 0; m_b = 0; m_out = 0; m_pc = 0; m_cf = 0;
        rst = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            pin = rand_in ? int'($urandom_range(0, 15)) : (i % 16);
            in_port = 4'(pin);
            prev_cf_clear = (m_cf == 0);
            model_step(pin);
            @(negedge clk);
            chk(tag, "pgm_addr", pgm_addr, m_pc);
            chk(tag, "out_port", out_port, m_out);
        end
    endtask

    task automatic clear_prog(logic [7:0] fill);
        for (int i = 0; i < 16; i++) prog[i] = fill;
    endtask

    initial begin
        clear_prog(8'h00);
        // R2 R3 R4: sources, sums, destinations
        prog[0] = 8'h35; prog[1] = 8'h09; prog[2] = 8'h40; prog[3] = 8'h53;
        prog[4] = 8'h90; prog[5] = 8'h20; prog[6] = 8'h40; prog[7] = 8'h92;
        prog[8] = 8'h64; prog[9] = 8'h90; prog[10] = 8'hB7; prog[11] = 8'hF0;
        run_prog("R2", 40, 1'b0);
        run_prog("R3", 40, 1'b1);
        run_prog("R4", 40, 1'b1);
        // R5 R7: carry set blocks JNC, carry clear takes it
        clear_prog(8'h00);
        prog[0] = 8'h3F; prog[1] = 8'h01; prog[2] = 8'hE6; prog[3] = 8'hB1;
        prog[4] = 8'h00; prog[5] = 8'hE8; prog[6] = 8'hBE; prog[7] = 8'hF0;
        prog[8] = 8'hB9; prog[9] = 8'hF0;
        run_prog("R5", 30, 1'b0);
        run_prog("R7", 30, 1'b0);
        // R8: aliased codes
        clear_prog(8'h00);
        prog[0] = 8'h73; prog[1] = 8'h82; prog[2] = 8'hA9; prog[3] = 8'h7A;
        prog[4] = 8'hC0; prog[5] = 8'h7F; prog[6] = 8'h01; prog[7] = 8'h01;
        prog[8] = 8'hD0; prog[15] = 8'hB4;
        run_prog("R8", 30, 1'b0);
        // R6 R10: straight-line code wraps, only A and B change
        clear_prog(8'h03);
        prog[5] = 8'h51; prog[9] = 8'h2C;
        run_prog("R6", 40, 1'b1);
        run_prog("R10", 40, 1'b1);
        // R1: random programs and input values
        for (int p = 0; p < 60; p++) begin
            for (int i = 0; i < 16; i++) prog[i] = 8'($urandom_range(0, 255));
            run_prog("R1", 64, 1'b1);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule